// File: doc/BRIEF.md
# UART Interrupt Status Aggregator

This block collects every interrupt-worthy event of a serial port and holds them in a 32-bit raw status word. The sources are end of transmission, receive overrun, break, parity error, framing error, receive timeout, transmit level, receive level and a change on the clear-to-send input. A mask register selects which raw bits reach a masked status word. The single interrupt line is the OR of that masked word. Software clears the latched bits by writing ones to a clear register.

The transmit and receive level interrupts follow the FIFO fill counts against programmable thresholds. When the FIFOs are disabled, each side behaves as a one-entry buffer. Each level source runs its own three-state machine:
- `LV_IDLE` goes to `LV_ACTIVE` when the condition holds.
- `LV_ACTIVE` goes back to `LV_IDLE` when the condition drops. It goes to `LV_HELD` when software writes the clear while the condition still holds.
- `LV_HELD` returns to `LV_IDLE` once the condition drops.

The end-of-transmission source uses a two-state tracker:
- `EOT_BUSY` goes to `EOT_DRAINED` when the transmit count is zero and the line is idle. That transition raises the event.
- `EOT_DRAINED` goes to `EOT_BUSY` as soon as either of those conditions stops holding.

The register port has four word addresses, read combinationally and written on the clock edge. FIFOs, shifters and baud timing live in neighbouring blocks, which feed this block's inputs.

Top module: `uart_irq_status`

## Requirements
- R1: While reset is held and in the first state after it, the raw word reads 0x0000_000D (reserved bits 0, 2 and 3 read 1). The mask is 0, the masked word is 0 and `irq` is 0.
- R2: Register addresses: 0 reads the raw word, 1 reads the masked word, 2 reads and writes the mask, and 3 is the write-one-to-clear register, which reads 0. Only mask bits 1 and 4 to 11 are writable; the others read 0. Writes to addresses 0 and 1 change nothing.
- R3: A write of 1 to a bit at address 3 clears that raw bit at the same clock edge, and a 0 bit leaves it alone. Reserved bits always stay at their reset value. An event arriving in the same cycle as its clear leaves the bit set.
- R4: With `fifo_en`=1, raw bit 5 (transmit) is set one edge after `tx_count <= tx_trig` holds. It drops one edge after that condition fails. A clear while the condition still holds keeps the bit low until the condition has failed and returned.
- R5: With `fifo_en`=1, raw bit 4 (receive) follows `rx_count >= rx_trig` with the same set, drop and clear-hold behaviour as R4.
- R6: With `fifo_en`=0, the transmit condition is `tx_count == 0`, the receive condition is `rx_count != 0`, and the receive side counts as full whenever `rx_count != 0`.
- R7: Raw bits 9 (break), 8 (parity) and 7 (framing) latch on their input pulses. Bit 1 latches on any change of `cts_in`. Bit 10 latches when `rx_push` arrives while the receive side is full; with FIFOs on, full means `rx_count == DEPTH`. All of these stay set until cleared.
- R8: Raw bit 11 latches once when the transmitter becomes drained, meaning `tx_count == 0` and `tx_line_idle` = 1, after having been busy. It does not latch again while the transmitter stays drained.
- R9: Raw bit 6 (receive timeout) latches on `rx_timeout` only while mask bit 6 is 1. It clears when `rx_count` is 0, when it is written at address 3, or when mask bit 6 becomes 0, so it never reads 1 with mask bit 6 at 0.
- R10: `masked_status` equals the raw word AND the mask, and `irq` is 1 exactly when `masked_status` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1: FIFO mode, 0: single-location mode |
| tx_count | input | CW | Transmit FIFO fill count |
| tx_trig | input | CW | Transmit threshold |
| tx_line_idle | input | 1 | Shifter has sent its last bit |
| rx_count | input | CW | Receive FIFO fill count |
| rx_trig | input | CW | Receive threshold |
| rx_push | input | 1 | Pulse: a received character arrives |
| rx_timeout | input | 1 | Pulse: receive idle timeout elapsed |
| brk_evt | input | 1 | Pulse: break detected |
| par_evt | input | 1 | Pulse: parity mismatch |
| frm_evt | input | 1 | Pulse: bad stop bit |
| cts_in | input | 1 | Clear-to-send line level |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| masked_status | output | 32 | Raw word AND mask |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that both fill counts stay within 0 to DEPTH. They also assume the error and timeout inputs are single-cycle pulses sampled at the clock edge, and that reset is applied before the first use. The stimulus draws counts and thresholds only from 0 to DEPTH. It drives every input on the falling edge and drops pulses and write strobes after one cycle. Random phases change at most a few inputs per cycle, so that both the level state machines and the sticky bits see every transition.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
    localparam int STAT_W = 32;

    // raw word bit positions
    localparam int B_CTS = 1;
    localparam int B_RXL = 4;
    localparam int B_TXL = 5;
    localparam int B_RTO = 6;
    localparam int B_FRM = 7;
    localparam int B_PAR = 8;
    localparam int B_BRK = 9;
    localparam int B_OVR = 10;
    localparam int B_EOT = 11;

    // compact index of latched sources
    localparam int S_CTS = 0;
    localparam int S_RTO = 1;
    localparam int S_FRM = 2;
    localparam int S_PAR = 3;
    localparam int S_BRK = 4;
    localparam int S_OVR = 5;
    localparam int S_EOT = 6;
    localparam int N_STICKY = 7;

    localparam int N_LEVEL = 2;  // 0: receive, 1: transmit

    localparam logic [STAT_W-1:0] RAW_RST   = 32'h0000_000D;
    localparam logic [STAT_W-1:0] IMPL_BITS = 32'h0000_0FF2;

    typedef enum logic [1:0] {
        A_RAW    = 2'd0,
        A_MASKED = 2'd1,
        A_MASK   = 2'd2,
        A_CLEAR  = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        LV_IDLE   = 2'd0,
        LV_ACTIVE = 2'd1,
        LV_HELD   = 2'd2
    } lvl_state_e;

    typedef enum logic {
        EOT_BUSY    = 1'b0,
        EOT_DRAINED = 1'b1
    } eot_state_e;
endpackage

// File: rtl/level_irq_fsm.sv
module level_irq_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    input  logic clr_i,
    output logic raw_o
);
    lvl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LV_IDLE:   if (cond_i) state_d = LV_ACTIVE;
            LV_ACTIVE: begin
                if (!cond_i)     state_d = LV_IDLE;
                else if (clr_i)  state_d = LV_HELD;
            end
            LV_HELD:   if (!cond_i) state_d = LV_IDLE;
            default:   state_d = LV_IDLE;
        endcase
    end

    always_comb begin
        raw_o = (state_q == LV_ACTIVE);
    end

    // R4/R5: a rise needs the condition one edge earlier
    a_r4_rise_needs_cond: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw_o) |-> $past(cond_i));
    // R5: a lost condition drops the bit at the next edge
    a_r5_drop_on_loss: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !cond_i) |=> !raw_o);
endmodule

// File: rtl/eot_tracker.sv
module eot_tracker
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty_i,
    input  logic line_idle_i,
    output logic done_o
);
    eot_state_e state_q, state_d;
    logic       drained;

    assign drained = tx_empty_i & line_idle_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EOT_DRAINED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EOT_BUSY:    if (drained)  state_d = EOT_DRAINED;
            EOT_DRAINED: if (!drained) state_d = EOT_BUSY;
            default:     state_d = EOT_DRAINED;
        endcase
    end

    always_comb begin
        done_o = (state_q == EOT_BUSY) && drained;
    end

    // R8: no completion event while the tracker already sits drained
    a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/sticky_bits.sv
module sticky_bits #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic [N-1:0] kill_i,
    output logic [N-1:0] q_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o[g] <= 1'b0;
            else        q_o[g] <= set_i[g] | (q_o[g] & ~clr_i[g] & ~kill_i[g]);
        end
    end
endmodule

// File: rtl/uart_irq_status.sv
module uart_irq_status
    import uart_irq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [CW-1:0] tx_count,
    input  logic [CW-1:0] tx_trig,
    input  logic          tx_line_idle,
    input  logic [CW-1:0] rx_count,
    input  logic [CW-1:0] rx_trig,
    input  logic          rx_push,
    input  logic          rx_timeout,
    input  logic          brk_evt,
    input  logic          par_evt,
    input  logic          frm_evt,
    input  logic          cts_in,
    input  logic [1:0]    reg_addr,
    input  logic          reg_wr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic [31:0]   masked_status,
    output logic          irq
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    reg_addr_e           addr;
    logic [STAT_W-1:0]   mask_q, mask_d, clr_word, raw;
    logic                cts_q, rx_full, rx_empty;
    logic [N_LEVEL-1:0]  lvl_cond, lvl_clr, lvl_raw;
    logic [N_STICKY-1:0] st_set, st_clr, st_kill, st_q;
    logic                eot_done;

    assign addr = reg_addr_e'(reg_addr);

    // register writes
    always_comb begin
        mask_d   = mask_q;
        clr_word = '0;
        if (reg_wr) begin
            unique case (addr)
                A_MASK:  mask_d   = reg_wdata & IMPL_BITS;
                A_CLEAR: clr_word = reg_wdata & IMPL_BITS;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            cts_q  <= 1'b1;
        end else begin
            mask_q <= mask_d;
            cts_q  <= cts_in;
        end
    end

    // FIFO-mode dependent conditions
    assign rx_empty = (rx_count == '0);
    assign rx_full  = fifo_en ? (rx_count == FULL_CNT) : !rx_empty;
    assign lvl_cond[0] = fifo_en ? (rx_count >= rx_trig) : !rx_empty;
    assign lvl_cond[1] = fifo_en ? (tx_count <= tx_trig) : (tx_count == '0);
    assign lvl_clr[0]  = clr_word[B_RXL];
    assign lvl_clr[1]  = clr_word[B_TXL];

    for (genvar g = 0; g < N_LEVEL; g++) begin : g_lvl
        level_irq_fsm u_lvl (
            .clk    (clk),
            .rst_n  (rst_n),
            .cond_i (lvl_cond[g]),
            .clr_i  (lvl_clr[g]),
            .raw_o  (lvl_raw[g])
        );
    end

    eot_tracker u_eot (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_empty_i  (tx_count == '0),
        .line_idle_i (tx_line_idle),
        .done_o      (eot_done)
    );

    // latched sources
    always_comb begin
        st_set         = '0;
        st_set[S_CTS]  = cts_in ^ cts_q;
        st_set[S_RTO]  = rx_timeout & mask_d[B_RTO];
        st_set[S_FRM]  = frm_evt;
        st_set[S_PAR]  = par_evt;
        st_set[S_BRK]  = brk_evt;
        st_set[S_OVR]  = rx_push & rx_full;
        st_set[S_EOT]  = eot_done;

        st_clr         = '0;
        st_clr[S_CTS]  = clr_word[B_CTS];
        st_clr[S_RTO]  = clr_word[B_RTO];
        st_clr[S_FRM]  = clr_word[B_FRM];
        st_clr[S_PAR]  = clr_word[B_PAR];
        st_clr[S_BRK]  = clr_word[B_BRK];
        st_clr[S_OVR]  = clr_word[B_OVR];
        st_clr[S_EOT]  = clr_word[B_EOT];

        st_kill        = '0;
        st_kill[S_RTO] = !mask_d[B_RTO] | rx_empty;
    end

    sticky_bits #(.N(N_STICKY)) u_sticky (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (st_set),
        .clr_i  (st_clr),
        .kill_i (st_kill),
        .q_o    (st_q)
    );

    // raw word assembly
    always_comb begin
        raw        = RAW_RST;
        raw[B_CTS] = st_q[S_CTS];
        raw[B_RXL] = lvl_raw[0];
        raw[B_TXL] = lvl_raw[1];
        raw[B_RTO] = st_q[S_RTO];
        raw[B_FRM] = st_q[S_FRM];
        raw[B_PAR] = st_q[S_PAR];
        raw[B_BRK] = st_q[S_BRK];
        raw[B_OVR] = st_q[S_OVR];
        raw[B_EOT] = st_q[S_EOT];
    end

    assign masked_status = raw & mask_q;
    assign irq           = |masked_status;

    always_comb begin
        unique case (addr)
            A_RAW:    reg_rdata = raw;
            A_MASKED: reg_rdata = masked_status;
            A_MASK:   reg_rdata = mask_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R3: a clear with no same-cycle event empties the parity bit
    a_r3_clear_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd3 && reg_wdata[B_PAR] && !par_evt) |=> !raw[B_PAR]);
    // R7: the parity bit holds without a clear
    a_r7_parity_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[B_PAR] && !(reg_wr && reg_addr == 2'd3 && reg_wdata[B_PAR])) |=> raw[B_PAR]);
    // R7: overrun only follows a push
    a_r7_overrun_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[B_OVR]) |-> $past(rx_push));
    // R8: completion follows a drained transmitter
    a_r8_eot_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(raw[B_EOT]) |-> $past(tx_count == '0 && tx_line_idle));
    // R9: timeout never raw without its mask bit
    a_r9_timeout_masked: assert property (@(posedge clk) disable iff (!rst_n)
        raw[B_RTO] |-> mask_q[B_RTO]);
    // R10: interrupt implies an enabled raw bit
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & mask_q) != '0));
endmodule

// File: tb/uart_irq_status_bench.sv
`timescale 1ns/1ps
module uart_irq_status_bench;
    localparam int DEPTH = 16;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b1;
    logic [CW-1:0] tx_count = '0, tx_trig = 5'd4, rx_count = '0, rx_trig = 5'd8;
    logic          tx_line_idle = 1'b1;
    logic          rx_push = 0, rx_timeout = 0, brk_evt = 0, par_evt = 0, frm_evt = 0;
    logic          cts_in = 1'b1;
    logic [1:0]    reg_addr = 2'd0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata, masked_status;
    logic          irq;

    uart_irq_status #(.DEPTH(DEPTH)) u_uart_irq_status (
        .clk, .rst_n, .fifo_en, .tx_count, .tx_trig, .tx_line_idle,
        .rx_count, .rx_trig, .rx_push, .rx_timeout, .brk_evt, .par_evt,
        .frm_evt, .cts_in, .reg_addr, .reg_wr, .reg_wdata, .reg_rdata,
        .masked_status, .irq
    );

    always #2 clk = ~clk;

    int n_checks = 0, n_fail = 0;
    bit finished = 0;
    string cur_tag = "R1";

    // reference model state
    logic [31:0] m_raw  = 32'h0000_000D;
    logic [31:0] m_mask = '0;
    int          m_lv[2] = '{0, 0};  // 0 idle, 1 active, 2 held; [0] rx, [1] tx
    bit          m_busy = 0;
    bit          m_cts  = 1;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_rdata();
        case (reg_addr)
            2'd0:    return m_raw;
            2'd1:    return m_raw & m_mask;
            2'd2:    return m_mask;
            default: return 32'h0;
        endcase
    endfunction

    task automatic compare_all();
        check(reg_rdata === exp_rdata(), cur_tag, reg_rdata, exp_rdata());
        check(masked_status === (m_raw & m_mask), "R10", masked_status, m_raw & m_mask);
        check(irq === |(m_raw & m_mask), "R10", {31'b0, irq}, {31'b0, |(m_raw & m_mask)});
    endtask

    function automatic int lv_next(input int s, input bit c, input bit clr);
        if (!c) return 0;
        if (s == 0) return 1;
        if (s == 1 && clr) return 2;
        return s;
    endfunction

    task automatic tick();
        logic [31:0] clr, mask_n, raw_n;
        bit txc, rxc, full, drained, rt_set;
        int lv0, lv1;
        clr    = (reg_wr && reg_addr == 2'd3) ? (reg_wdata & 32'hFF2) : 32'h0;
        mask_n = (reg_wr && reg_addr == 2'd2) ? (reg_wdata & 32'hFF2) : m_mask;
        txc  = fifo_en ? (tx_count <= tx_trig) : (tx_count == 0);
        rxc  = fifo_en ? (rx_count >= rx_trig) : (rx_count != 0);
        full = fifo_en ? (rx_count == DEPTH) : (rx_count != 0);
        lv0 = lv_next(m_lv[0], rxc, clr[4]);
        lv1 = lv_next(m_lv[1], txc, clr[5]);
        drained = (tx_count == 0) && tx_line_idle;
        raw_n = (m_raw & ~clr) | 32'h0000_000D;
        if (cts_in != m_cts)        raw_n[1]  = 1'b1;
        if (frm_evt)                raw_n[7]  = 1'b1;
        if (par_evt)                raw_n[8]  = 1'b1;
        if (brk_evt)                raw_n[9]  = 1'b1;
        if (rx_push && full)        raw_n[10] = 1'b1;
        if (m_busy && drained)      raw_n[11] = 1'b1;
        if (!mask_n[6] || rx_count == 0) raw_n[6] = 1'b0;
        rt_set = rx_timeout && mask_n[6];
        if (rt_set)                 raw_n[6]  = 1'b1;
        raw_n[4] = (lv0 == 1);
        raw_n[5] = (lv1 == 1);
        @(posedge clk);
        @(negedge clk);
        m_raw = raw_n; m_mask = mask_n; m_lv[0] = lv0; m_lv[1] = lv1;
        m_busy = !drained; m_cts = cts_in;
        compare_all();
        rx_push = 0; rx_timeout = 0; brk_evt = 0; par_evt = 0; frm_evt = 0;
        reg_wr = 0; reg_addr = 2'd0; reg_wdata = '0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        tick();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #200000;
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1 reset
        #5;
        check(reg_rdata === 32'h0000_000D, "R1", reg_rdata, 32'h0000_000D);
        reg_addr = 2'd2; #1;
        check(reg_rdata === 32'h0, "R1", reg_rdata, 32'h0);
        check(irq === 1'b0, "R1", {31'b0, irq}, 32'h0);
        reg_addr = 2'd0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        check(masked_status === 32'h0, "R1", masked_status, 32'h0);
        tick();

        // R2 register map
        cur_tag = "R2";
        wr(2'd2, 32'hFFFF_FFFF);
        reg_addr = 2'd2; #1;
        check(reg_rdata === 32'h0000_0FF2, "R2", reg_rdata, 32'h0000_0FF2);
        reg_addr = 2'd1; #1;
        check(reg_rdata === (m_raw & m_mask), "R2", reg_rdata, m_raw & m_mask);
        reg_addr = 2'd3; #1;
        check(reg_rdata === 32'h0, "R2", reg_rdata, 32'h0);
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        idle(2);

        // R4 transmit level, FIFO mode
        cur_tag = "R4";
        tx_count = 5'd6; idle(2);
        tx_count = 5'd4; idle(2);
        wr(2'd3, 32'h20);
        tx_count = 5'd2; idle(2);
        tx_count = 5'd5; idle(1);
        tx_count = 5'd3; idle(2);

        // R5 receive level, FIFO mode
        cur_tag = "R5";
        rx_count = 5'd7; idle(2);
        rx_count = 5'd8; idle(1);
        rx_count = 5'd9; idle(1);
        wr(2'd3, 32'h10);
        rx_count = 5'd10; idle(1);
        rx_count = 5'd7; idle(2);
        rx_count = 5'd8; idle(1);

        // R7 latched errors, CTS, overrun at full
        cur_tag = "R7";
        brk_evt = 1; tick();
        par_evt = 1; tick();
        frm_evt = 1; tick();
        cts_in = 0; idle(2);
        rx_count = 5'd15; rx_push = 1; tick();
        rx_count = 5'd16; rx_push = 1; tick();
        idle(2);

        // R3 clear semantics
        cur_tag = "R3";
        wr(2'd3, 32'h0);
        par_evt = 1; reg_addr = 2'd3; reg_wr = 1; reg_wdata = 32'h100; tick();
        wr(2'd3, 32'h0000_078D);
        wr(2'd3, 32'hFFFF_F00F);
        idle(1);

        // R6 FIFO-disabled mode
        cur_tag = "R6";
        fifo_en = 0; rx_count = 0; tx_count = 5'd1; idle(2);
        tx_count = 5'd0; idle(2);
        rx_count = 5'd1; idle(2);
        rx_push = 1; tick();
        wr(2'd3, 32'h10);
        rx_count = 5'd0; idle(2);
        fifo_en = 1; idle(1);

        // R8 end of transmission
        cur_tag = "R8";
        wr(2'd3, 32'h800);
        tx_count = 5'd3; tx_line_idle = 0; idle(2);
        tx_count = 5'd0; idle(2);
        tx_line_idle = 1; idle(2);
        wr(2'd3, 32'h800);
        idle(3);

        // R9 receive timeout gated by mask
        cur_tag = "R9";
        wr(2'd2, 32'h0000_0FB2);
        rx_count = 5'd5; rx_timeout = 1; tick();
        wr(2'd2, 32'h0000_0FF2);
        rx_timeout = 1; tick();
        idle(1);
        rx_count = 5'd0; idle(2);
        rx_count = 5'd3; rx_timeout = 1; tick();
        wr(2'd2, 32'h0000_0FB2);
        idle(1);
        wr(2'd2, 32'h0000_0FF2);
        rx_timeout = 1; tick();
        wr(2'd3, 32'h40);

        // R10 mixed pseudo-random traffic
        cur_tag = "R10";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            case (r)
                0: tx_count = CW'($urandom_range(0, DEPTH));
                1: rx_count = CW'($urandom_range(0, DEPTH));
                2: tx_trig  = CW'($urandom_range(0, DEPTH));
                3: rx_trig  = CW'($urandom_range(0, DEPTH));
                4: tx_line_idle = ~tx_line_idle;
                5: rx_push = 1;
                6: rx_timeout = 1;
                7: brk_evt = 1;
                8: par_evt = 1;
                9: frm_evt = 1;
                10: cts_in = ~cts_in;
                11: begin reg_addr = 2'd3; reg_wr = 1; reg_wdata = $urandom; end
                12: begin reg_addr = 2'd2; reg_wr = 1; reg_wdata = $urandom; end
                13: if ($urandom_range(0, 7) == 0) fifo_en = ~fifo_en;
                default: reg_addr = 2'($urandom_range(0, 3));
            endcase
            tick();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule